// File: doc/BRIEF.md
# Cascaded Delay Chain Controller

This block drives a chain of identical programmable delay elements from one wide delay request. The first element of the chain gets a 10-bit code taken from the low bits of the request. Every further element has no code of its own. Its minimum-delay or maximum-delay override is asserted, and one extra request bit per added element picks which. Each added element therefore contributes either nothing or one full element span of 1024 steps. The programmable range grows by one request bit per element.

A request is taken on a one-cycle load strobe. The controller first presents the new settings with the element latch enable held high. It then drops the latch enable for one cycle so that all elements take the settings together, and raises it again to lock them. When the lock happens, the controller also publishes a predicted total delay in picoseconds. This prediction is computed from the settings it actually drives and includes the fixed base delay of every element in the chain.

Top module: `dly_cascade_ctrl`

## Requirements
- R1: The first element's code output equals request bits [9:0], and both of that element's overrides (bit 0 of `set_min` and of `set_max`) are always 0.
- R2: For each downstream element k (k = 1 to N_STAGES-1), request bit 9+k set gives `set_max[k]`=1 and `set_min[k]`=0. With that bit clear, `set_min[k]`=1 and `set_max[k]`=0.
- R3: Settings outputs change only while `latch_en` is high and was high in the previous cycle. A strobe sampled at clock edge E0 makes the new settings visible right after E0.
- R4: After a strobe accepted at E0, `latch_en` is high after E0, low after E1 and high again after E2. It never stays low for more than one cycle.
- R5: `total_ps` changes only in the cycle where `latch_en` rises. It then equals UNIT_PS × (code + 1024 × number of set cascade bits) + N_STAGES × BASE_PS.
- R6: With the default two elements (10 ps step, 2200 ps base), request 0 gives 4400 ps, request 0x3FF gives 14630 ps, request 0x400 gives 14640 ps and request 0x7FF gives 24870 ps.
- R7: A strobe that arrives while a load sequence is in progress is ignored. The settings keep the first request and no second latch pulse follows.
- R8: While reset is active, and right after it, the code is 0, `set_min` is 1 for every downstream element, `set_max` is all 0, `latch_en` is 1 and `total_ps` equals N_STAGES × BASE_PS. Asserting `rst_n` takes effect at once, without waiting for a clock edge.
- R9: `total_ps` is never below N_STAGES × BASE_PS, the floor that chaining imposes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_load | input | 1 | One-cycle strobe that accepts `req_word` |
| req_word | input | REQ_W (CODE_W+N_STAGES-1) | Delay request: bits [9:0] are the fine code, the bits above are one cascade bit per added element |
| code0 | output | CODE_W | Code for the first element |
| set_min | output | N_STAGES | Minimum-delay override, one bit per element |
| set_max | output | N_STAGES | Maximum-delay override, one bit per element |
| latch_en | output | 1 | Element latch enable: low = transparent, high = hold |
| total_ps | output | TOT_W | Predicted total chain delay in picoseconds |

## Verification
A wrong captured request shows up on `code0` and the override pins right after the accepting edge. A wrong sequencer state shows up on `latch_en` one edge later, as a missing, early or stretched low pulse. A mistake in the delay model or in its commit shows up only on `total_ps`, right after the rising latch edge. The bench therefore samples every output after each of the three edges of a load. Request patterns either side of each cascade boundary expose off-by-one-element faults.

// File: rtl/dly_cascade_pkg.sv
package dly_cascade_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SETUP = 2'd1,
    SEQ_OPEN  = 2'd2
  } seq_state_e;

  // Largest predicted chain delay in ps, used to size the total output.
  function automatic int unsigned max_total_ps(input int unsigned n_stages,
                                               input int unsigned code_w,
                                               input int unsigned unit_ps,
                                               input int unsigned base_ps);
    int unsigned span;
    span = 1 << code_w;
    return unit_ps * ((span - 1) + span * (n_stages - 1)) + n_stages * base_ps;
  endfunction

endpackage

// File: rtl/dly_rst_sync.sv
module dly_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/dly_load_seq.sv
module dly_load_seq
  import dly_cascade_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic commit,
  output logic latch_en
);

  seq_state_e state_q, state_d;
  logic       latch_q, latch_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:  if (start) state_d = SEQ_SETUP;
      SEQ_SETUP: state_d = SEQ_OPEN;
      SEQ_OPEN:  state_d = SEQ_IDLE;
      default:   state_d = SEQ_IDLE;
    endcase
    latch_d = (state_d != SEQ_OPEN);
  end

  assign accept = (state_q == SEQ_IDLE) && start;
  assign commit = (state_q == SEQ_OPEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      latch_q <= 1'b1;
    end else begin
      state_q <= state_d;
      latch_q <= latch_d;
    end
  end

  assign latch_en = latch_q;

  // R4: the transparent window is exactly one cycle wide
  a_r4_single_open_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_en) |=> latch_en);

  // R4: the window opens only from the settle cycle
  a_r4_open_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_en) |-> $past(state_q) == SEQ_SETUP);

endmodule

// File: rtl/dly_stage_map.sv
module dly_stage_map #(
  parameter int unsigned N_STAGES = 2,
  parameter int unsigned CODE_W   = 10,
  localparam int unsigned REQ_W   = CODE_W + N_STAGES - 1
) (
  input  logic [REQ_W-1:0]    req_q,
  output logic [CODE_W-1:0]   code0,
  output logic [N_STAGES-1:0] set_min,
  output logic [N_STAGES-1:0] set_max
);

  // Head element: code from the low request bits, overrides released.
  assign code0      = req_q[CODE_W-1:0];
  assign set_min[0] = 1'b0;
  assign set_max[0] = 1'b0;

  // Each downstream element follows its own cascade bit.
  for (genvar k = 1; k < N_STAGES; k++) begin : g_down
    logic casc_bit;
    assign casc_bit   = req_q[CODE_W+k-1];
    assign set_max[k] = casc_bit;
    assign set_min[k] = ~casc_bit;
  end

endmodule

// File: rtl/dly_total_model.sv
module dly_total_model #(
  parameter int unsigned N_STAGES = 2,
  parameter int unsigned CODE_W   = 10,
  parameter int unsigned UNIT_PS  = 10,
  parameter int unsigned BASE_PS  = 2200,
  parameter int unsigned TOT_W    = 15
) (
  input  logic [CODE_W-1:0]   code0,
  input  logic [N_STAGES-1:0] set_min,
  input  logic [N_STAGES-1:0] set_max,
  output logic [TOT_W-1:0]    total_d
);

  localparam int unsigned FULL_STEPS = 1 << CODE_W;

  logic [TOT_W-1:0] elem_ps [N_STAGES];

  for (genvar k = 0; k < N_STAGES; k++) begin : g_elem
    logic [CODE_W-1:0] elem_code;
    logic [TOT_W-1:0]  steps;

    if (k == 0) begin : g_head
      assign elem_code = code0;
    end else begin : g_tail
      assign elem_code = '0;
    end

    // Minimum override wins over maximum, as in the element itself.
    always_comb begin
      if (set_min[k]) begin
        steps = '0;
      end else if (set_max[k]) begin
        steps = TOT_W'(FULL_STEPS);
      end else begin
        steps = TOT_W'(elem_code);
      end
      elem_ps[k] = TOT_W'(BASE_PS) + TOT_W'(UNIT_PS) * steps;
    end
  end

  always_comb begin
    total_d = '0;
    for (int k = 0; k < N_STAGES; k++) begin
      total_d = total_d + elem_ps[k];
    end
  end

endmodule

// File: rtl/dly_cascade_ctrl.sv
module dly_cascade_ctrl
  import dly_cascade_pkg::*;
#(
  parameter int unsigned N_STAGES = 2,
  parameter int unsigned CODE_W   = 10,
  parameter int unsigned UNIT_PS  = 10,
  parameter int unsigned BASE_PS  = 2200,
  localparam int unsigned REQ_W   = CODE_W + N_STAGES - 1,
  localparam int unsigned TOT_W   =
    $clog2(max_total_ps(N_STAGES, CODE_W, UNIT_PS, BASE_PS) + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_load,
  input  logic [REQ_W-1:0]    req_word,
  output logic [CODE_W-1:0]   code0,
  output logic [N_STAGES-1:0] set_min,
  output logic [N_STAGES-1:0] set_max,
  output logic                latch_en,
  output logic [TOT_W-1:0]    total_ps
);

  localparam logic [TOT_W-1:0] FLOOR_PS = TOT_W'(N_STAGES * BASE_PS);

  logic             rst_n_s;
  logic             accept;
  logic             commit;
  logic [REQ_W-1:0] req_q, req_d;
  logic [TOT_W-1:0] total_q, total_d, model_ps;

  dly_rst_sync i_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  dly_load_seq i_seq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start    (req_load),
    .accept   (accept),
    .commit   (commit),
    .latch_en (latch_en)
  );

  // Request register: loads only when the sequencer accepts.
  always_comb begin
    req_d = req_q;
    if (accept) req_d = req_word;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      req_q <= '0;
    end else begin
      req_q <= req_d;
    end
  end

  dly_stage_map #(
    .N_STAGES (N_STAGES),
    .CODE_W   (CODE_W)
  ) i_map (
    .req_q   (req_q),
    .code0   (code0),
    .set_min (set_min),
    .set_max (set_max)
  );

  dly_total_model #(
    .N_STAGES (N_STAGES),
    .CODE_W   (CODE_W),
    .UNIT_PS  (UNIT_PS),
    .BASE_PS  (BASE_PS),
    .TOT_W    (TOT_W)
  ) i_model (
    .code0   (code0),
    .set_min (set_min),
    .set_max (set_max),
    .total_d (model_ps)
  );

  // Published total moves together with the lock edge.
  always_comb begin
    total_d = total_q;
    if (commit) total_d = model_ps;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      total_q <= FLOOR_PS;
    end else begin
      total_q <= total_d;
    end
  end

  assign total_ps = total_q;

  // R3: settings move only while the elements hold
  a_r3_settings_move_in_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$stable({code0, set_min, set_max}) |-> latch_en && $past(latch_en));

  // R3: settings are steady across the transparent cycle
  a_r3_steady_while_open: assert property (@(posedge clk) disable iff (!rst_n_s)
    !latch_en |=> $stable({code0, set_min, set_max}));

  // R5: the published total changes only on the lock edge
  a_r5_total_at_lock: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$stable(total_ps) |-> $rose(latch_en));

  // R9: the chain never reports less than its fixed floor
  a_r9_floor: assert property (@(posedge clk) disable iff (!rst_n_s)
    total_ps >= FLOOR_PS);

endmodule

// File: tb/test_dly_cascade_ctrl.sv
module test_dly_cascade_ctrl;

  localparam int N   = 2;
  localparam int CW  = 10;
  localparam int UPS = 10;
  localparam int BPS = 2200;
  localparam int RW  = CW + N - 1;
  localparam int TW  = $clog2(UPS * (((1 << CW) - 1) + (1 << CW) * (N - 1)) + N * BPS + 1);
  localparam int NV  = 11;

  localparam logic [RW-1:0] VREQ [NV] = '{
    11'h000, 11'h001, 11'h002, 11'h007, 11'h0AA, 11'h200,
    11'h3FF, 11'h400, 11'h401, 11'h600, 11'h7FF
  };
  localparam int VTOT [NV] = '{
    4400, 4410, 4420, 4470, 6100, 9520,
    14630, 14640, 14650, 19760, 24870
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_load;
  logic [RW-1:0] req_word;
  logic [CW-1:0] code0;
  logic [N-1:0]  set_min;
  logic [N-1:0]  set_max;
  logic          latch_en;
  logic [TW-1:0] total_ps;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int cur_tot;

  always #4 clk = ~clk;

  dly_cascade_ctrl #(
    .N_STAGES (N),
    .CODE_W   (CW),
    .UNIT_PS  (UPS),
    .BASE_PS  (BPS)
  ) i_dly_cascade_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_load (req_load),
    .req_word (req_word),
    .code0    (code0),
    .set_min  (set_min),
    .set_max  (set_max),
    .latch_en (latch_en),
    .total_ps (total_ps)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_total(input logic [RW-1:0] r);
    int s = int'(r[CW-1:0]);
    for (int k = 0; k < N - 1; k++) if (r[CW+k]) s += (1 << CW);
    return UPS * s + N * BPS;
  endfunction

  function automatic int exp_min(input logic [RW-1:0] r);
    int m = 0;
    for (int k = 1; k < N; k++) if (!r[CW+k-1]) m |= (1 << k);
    return m;
  endfunction

  function automatic int exp_max(input logic [RW-1:0] r);
    int m = 0;
    for (int k = 1; k < N; k++) if (r[CW+k-1]) m |= (1 << k);
    return m;
  endfunction

  task automatic check_reset_state(input string when);
    chk({"R8 code ", when}, int'(code0), 0);
    chk({"R8 set_min ", when}, int'(set_min), exp_min('0));
    chk({"R8 set_max ", when}, int'(set_max), 0);
    chk({"R8 latch_en ", when}, int'(latch_en), 1);
    chk({"R8 total ", when}, int'(total_ps), N * BPS);
  endtask

  // Full load sequence with samples after each of the three edges.
  task automatic run_load(input logic [RW-1:0] r);
    @(negedge clk); req_word = r; req_load = 1'b1;
    @(negedge clk); req_load = 1'b0;
    chk("R1 code after accept", int'(code0), int'(r[CW-1:0]));
    chk("R1 head overrides", int'({set_min[0], set_max[0]}), 0);
    chk("R2 set_min", int'(set_min), exp_min(r));
    chk("R2 set_max", int'(set_max), exp_max(r));
    chk("R4 latch high after E0", int'(latch_en), 1);
    chk("R5 total held after E0", int'(total_ps), cur_tot);
    @(negedge clk);
    chk("R4 latch low after E1", int'(latch_en), 0);
    chk("R3 code steady while open", int'(code0), int'(r[CW-1:0]));
    chk("R5 total held after E1", int'(total_ps), cur_tot);
    @(negedge clk);
    chk("R4 latch high after E2", int'(latch_en), 1);
    chk("R5 total after lock", int'(total_ps), exp_total(r));
    cur_tot = exp_total(r);
  endtask

  initial begin
    rst_n    = 1'b0;
    req_load = 1'b0;
    req_word = '0;
    cur_tot  = N * BPS;
    repeat (3) @(negedge clk);
    check_reset_state("during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state("after release");

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      run_load(VREQ[i]);
      chk("R6 table total", int'(total_ps), VTOT[i]);
    end

    // R9: back to code 0 reaches the floor exactly
    run_load('0);
    chk("R9 floor at code 0", int'(total_ps), N * BPS);

    // R7: strobe during a running sequence is ignored
    @(negedge clk); req_word = 11'h155; req_load = 1'b1;
    @(negedge clk); req_word = 11'h2AA; req_load = 1'b1;
    @(negedge clk); req_load = 1'b0;
    chk("R7 latch low once", int'(latch_en), 0);
    @(negedge clk);
    chk("R7 total keeps first request", int'(total_ps), exp_total(11'h155));
    chk("R7 code keeps first request", int'(code0), 'h155);
    @(negedge clk);
    chk("R7 no second latch pulse", int'(latch_en), 1);
    chk("R7 code unchanged later", int'(code0), 'h155);
    @(negedge clk);
    chk("R7 latch still high", int'(latch_en), 1);
    cur_tot = exp_total(11'h155);

    // R8: asynchronous reset in the middle of a sequence
    @(negedge clk); req_word = 11'h7FF; req_load = 1'b1;
    @(negedge clk); req_load = 1'b0;
    #1 rst_n = 1'b0;
    #1 check_reset_state("mid-sequence");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state("after second release");
    cur_tot = N * BPS;
    run_load(11'h401);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule